// File: doc/BRIEF.md
# Truncating Float-to-Fixed Converter

This unit takes one IEEE-754 operand in half, single or double precision and turns it into a signed two's-complement number that is 32 or 64 bits wide. The conversion always truncates toward zero. An optional fixed-point mode first multiplies the operand by 2^fbits, so the result carries fbits fractional bits. If the truncated value does not fit the chosen width, the result saturates to the limit on the side of the operand's sign.

Each conversion takes one cycle. The caller presents an operand with `in_valid`. One clock later, `out_valid` rises together with the result and two single-cycle exception pulses. `flag_invalid` marks a NaN operand or a saturated result. `flag_inexact` marks a result from which nonzero fraction bits were dropped. The unit touches no condition codes. The two flags are its only side outputs, and the surrounding logic can merge them into its sticky status.

Top module: `fcvt_trunc_unit`

## Requirements
- R1: `src_fmt` selects the operand format. 2'b00 is single precision (operand[31:0]), 2'b01 is double precision (operand[63:0]) and 2'b11 is half precision (operand[15:0]). Operand bits above the selected format are ignored. In integer mode, a finite in-range value is truncated toward zero for both signs.
- R2: `dst_wide`=1 gives a 64-bit result. `dst_wide`=0 gives a 32-bit two's-complement result in result[31:0], with result[63:32] forced to zero.
- R3: When the truncated value lies outside the signed destination range, or the operand is an infinity, the result is the most negative value for a negative operand and the most positive value otherwise. `flag_invalid` is 1 and `flag_inexact` is 0.
- R4: A NaN operand of either sign gives a result of 0 with `flag_invalid`=1 and `flag_inexact`=0.
- R5: `flag_inexact` is 1 exactly when the conversion does not saturate, the operand is not NaN, and the discarded fraction is nonzero. An exact conversion raises neither flag.
- R6: With `fix_en`=1, fbits = 64 − `scale`, and the operand is multiplied by 2^fbits before truncation. The driven range is fbits 1..64 for 64-bit results and 1..32 for 32-bit results. With `fix_en`=0, `scale` has no effect.
- R7: Both signed zeros give 0 with no flags. Subnormal operands are converted by their true value, so in integer mode they give 0 with `flag_inexact`=1.
- R8: `out_valid` is `in_valid` delayed by one clock. The flags are nonzero only in a cycle with `out_valid`=1. Reset clears `out_valid`, `result` and both flags.
- R9: An operand equal to exactly −2^(W−1) for the chosen width W converts to the most negative value with no flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | Raw floating-point bits, right-aligned |
| src_fmt | input | 2 | Source format code (00 single, 01 double, 11 half) |
| dst_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| fix_en | input | 1 | Enable fixed-point scaling |
| scale | input | 6 | Scale code; fbits = 64 − scale |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Converted signed value |
| flag_invalid | output | 1 | Invalid-operation pulse |
| flag_inexact | output | 1 | Inexact pulse |

## Verification
The assertions hold on every cycle:
- the one-cycle valid timing;
- flags appearing only alongside a result;
- the two flags never occurring together;
- zeroed upper bits for 32-bit results;
- an invalid 64-bit result always being 0 or one of the two saturation limits.

Only the bench's scenarios can show that the numeric value is right. These scenarios cover:
- truncation direction for each format;
- fixed-point scaling;
- subnormal handling;
- the exact negative boundary;
- inexact detection.

A reference model in the bench, built by bit-serial shifting, serves as the comparison for both the directed cases and a pseudo-random sweep.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int SIG_W = 53;   // widest significand including hidden bit
    localparam int XW    = 13;   // signed exponent width after scaling

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_HALF   = 2'b11
    } src_fmt_e;

    // significand left-aligned so that sig[SIG_W-1] weighs 2^exp
    typedef struct packed {
        logic                  sign;
        logic                  nan;
        logic                  inf;
        logic signed [XW-1:0]  exp;
        logic [SIG_W-1:0]      sig;
    } fp_parts_t;
endpackage

// File: rtl/fcvt_field_split.sv
module fcvt_field_split
    import fcvt_pkg::*;
#(
    parameter int EW = 11,
    parameter int MW = 52
) (
    input  logic [EW+MW:0] bits_in,
    output fp_parts_t      parts
);
    localparam int BIAS = (1 << (EW - 1)) - 1;

    logic [EW-1:0] ef;
    logic [MW-1:0] fr;

    always_comb begin
        ef = bits_in[EW+MW-1:MW];
        fr = bits_in[MW-1:0];
        parts.sign = bits_in[EW+MW];
        parts.nan  = (&ef) && (|fr);
        parts.inf  = (&ef) && !(|fr);
        parts.sig  = SIG_W'({(ef != '0), fr}) << (SIG_W - 1 - MW);
        if (ef == '0)
            parts.exp = XW'(1) - XW'(BIAS);
        else
            parts.exp = XW'(ef) - XW'(BIAS);
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic [SIG_W-1:0]      sig,
    input  logic signed [XW-1:0]  exp_s,
    output logic [INT_W-1:0]      mag,
    output logic                  lost,
    output logic                  big
);
    localparam int SHW = $clog2(INT_W);
    localparam logic signed [XW-1:0] TOP_E = XW'(INT_W);

    logic [2*INT_W-1:0] window;
    logic [SHW-1:0]     sh;

    always_comb begin
        sh     = SHW'(INT_W - 1) - SHW'(exp_s);
        window = {sig, {(2*INT_W-SIG_W){1'b0}}} >> sh;
        big    = 1'b0;
        mag    = '0;
        lost   = 1'b0;
        if (exp_s >= TOP_E) begin
            big = |sig;
        end else if (exp_s[XW-1]) begin
            lost = |sig;
        end else begin
            mag  = window[2*INT_W-1:INT_W];
            lost = |window[INT_W-1:0];
        end
    end
endmodule

// File: rtl/fcvt_clamp.sv
module fcvt_clamp #(
    parameter int INT_W = 64
) (
    input  logic             sign,
    input  logic [INT_W-1:0] mag,
    input  logic             big,
    input  logic             wide,
    output logic [INT_W-1:0] value,
    output logic             ovf
);
    localparam int HALF = INT_W / 2;
    localparam logic [INT_W-1:0] ONE      = INT_W'(1);
    localparam logic [INT_W-1:0] WIDE_MIN = ONE << (INT_W - 1);
    localparam logic [INT_W-1:0] NARR_MIN = ONE << (HALF - 1);

    logic [INT_W-1:0] lim_mag;
    logic [INT_W-1:0] sat;
    logic [INT_W-1:0] signed_v;

    always_comb begin
        lim_mag  = (wide ? WIDE_MIN : NARR_MIN) - (sign ? '0 : ONE);
        ovf      = big || (mag > lim_mag);
        if (wide)
            sat = sign ? WIDE_MIN : ~WIDE_MIN;
        else
            sat = sign ? NARR_MIN : NARR_MIN - ONE;
        signed_v = sign ? (~mag + ONE) : mag;
        if (ovf)
            value = sat;
        else if (wide)
            value = signed_v;
        else
            value = {{(INT_W-HALF){1'b0}}, signed_v[HALF-1:0]};
    end
endmodule

// File: rtl/fcvt_trunc_unit.sv
module fcvt_trunc_unit
    import fcvt_pkg::*;
#(
    parameter int INT_W   = 64,
    parameter int SCALE_W = $clog2(INT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INT_W-1:0]   operand,
    input  logic [1:0]         src_fmt,
    input  logic               dst_wide,
    input  logic               fix_en,
    input  logic [SCALE_W-1:0] scale,
    output logic               out_valid,
    output logic [INT_W-1:0]   result,
    output logic               flag_invalid,
    output logic               flag_inexact
);
    localparam int NFMT = 3;
    localparam int EW_T [NFMT] = '{11, 8, 5};
    localparam int MW_T [NFMT] = '{52, 23, 10};

    typedef struct packed {
        logic             valid;
        logic             invalid;
        logic             inexact;
        logic [INT_W-1:0] value;
    } stage_t;

    stage_t stage_d, stage_q;

    fp_parts_t parts [NFMT];
    fp_parts_t sel;

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        fcvt_field_split #(
            .EW(EW_T[g]),
            .MW(MW_T[g])
        ) u_split (
            .bits_in(operand[EW_T[g]+MW_T[g]:0]),
            .parts  (parts[g])
        );
    end

    logic [SCALE_W:0]      fbits;
    logic signed [XW-1:0]  exp_s;
    logic [INT_W-1:0]      mag;
    logic                  lost;
    logic                  big;
    logic [INT_W-1:0]      clamp_val;
    logic                  ovf;

    always_comb begin
        case (src_fmt_e'(src_fmt))
            FMT_DOUBLE: sel = parts[0];
            FMT_HALF:   sel = parts[2];
            default:    sel = parts[1];
        endcase
        fbits = fix_en ? ((SCALE_W+1)'(INT_W) - {1'b0, scale}) : '0;
        exp_s = sel.exp + XW'(fbits);
    end

    fcvt_align #(.INT_W(INT_W)) u_align (
        .sig  (sel.sig),
        .exp_s(exp_s),
        .mag  (mag),
        .lost (lost),
        .big  (big)
    );

    fcvt_clamp #(.INT_W(INT_W)) u_clamp (
        .sign (sel.sign),
        .mag  (mag),
        .big  (big || sel.inf),
        .wide (dst_wide),
        .value(clamp_val),
        .ovf  (ovf)
    );

    always_comb begin
        stage_d         = stage_q;
        stage_d.valid   = in_valid;
        stage_d.invalid = 1'b0;
        stage_d.inexact = 1'b0;
        if (in_valid) begin
            if (sel.nan) begin
                stage_d.value   = '0;
                stage_d.invalid = 1'b1;
            end else begin
                stage_d.value   = clamp_val;
                stage_d.invalid = ovf;
                stage_d.inexact = !ovf && lost;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign out_valid    = stage_q.valid;
    assign result       = stage_q.value;
    assign flag_invalid = stage_q.invalid;
    assign flag_inexact = stage_q.inexact;
endmodule

// File: rtl/fcvt_trunc_unit_chk.sv
module fcvt_trunc_unit_chk #(
    parameter int INT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             dst_wide,
    input logic             out_valid,
    input logic [INT_W-1:0] result,
    input logic             flag_invalid,
    input logic             flag_inexact
);
    localparam logic [INT_W-1:0] MIN_W = INT_W'(1) << (INT_W - 1);

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_flags_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_invalid || flag_inexact) |-> out_valid);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_invalid && flag_inexact));

    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dst_wide) |=> (result[INT_W-1:INT_W/2] == '0));

    assert_invalid_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst_wide) |=>
            (!flag_invalid || result == '0 || result == MIN_W || result == ~MIN_W));
endmodule

bind fcvt_trunc_unit fcvt_trunc_unit_chk #(.INT_W(INT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .dst_wide    (dst_wide),
    .out_valid   (out_valid),
    .result      (result),
    .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact)
);

// File: tb/fcvt_trunc_unit_test.sv
module fcvt_trunc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  src_fmt = 2'b00;
    logic        dst_wide = 1'b0;
    logic        fix_en = 1'b0;
    logic [5:0]  scale = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid;
    logic        flag_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fcvt_trunc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .src_fmt(src_fmt), .dst_wide(dst_wide), .fix_en(fix_en), .scale(scale),
        .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    // bit-serial reference built from the requirements
    function automatic void ref_conv(input logic [63:0] op, input logic [1:0] fmt,
                                     input logic wide, input logic fix, input logic [5:0] sc,
                                     output logic [63:0] res, output logic inv, output logic inx);
        int ebits, mbits, bias, k, fb;
        logic [63:0] expf, frac, sig;
        logic [127:0] mag, lim;
        logic sgn, sticky, big;
        case (fmt)
            2'b01:   begin ebits = 11; mbits = 52; end
            2'b11:   begin ebits = 5;  mbits = 10; end
            default: begin ebits = 8;  mbits = 23; end
        endcase
        bias = (1 << (ebits - 1)) - 1;
        expf = (op >> mbits) & ((64'd1 << ebits) - 64'd1);
        frac = op & ((64'd1 << mbits) - 64'd1);
        sgn  = op[ebits + mbits];
        inv = 1'b0; inx = 1'b0; res = '0; big = 1'b0; sticky = 1'b0; mag = '0;
        if (expf == ((64'd1 << ebits) - 64'd1) && frac != 0) begin
            inv = 1'b1;
            return;
        end
        if (expf == ((64'd1 << ebits) - 64'd1)) big = 1'b1;
        sig = (expf == 0) ? frac : (frac | (64'd1 << mbits));
        k   = ((expf == 0) ? 1 : int'(expf)) - bias - mbits;
        fb  = fix ? (64 - int'(sc)) : 0;
        k   = k + fb;
        if (!big && sig != 0) begin
            if (k > 70) big = 1'b1;
            else if (k >= 0) mag = 128'(sig) << k;
            else begin
                mag = 128'(sig);
                for (int i = 0; i < -k; i++) begin
                    sticky = sticky | mag[0];
                    mag = mag >> 1;
                end
            end
        end
        lim = (128'd1 << (wide ? 63 : 31)) - (sgn ? 128'd0 : 128'd1);
        if (big || mag > lim) begin
            inv = 1'b1;
            if (wide) res = sgn ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
            else      res = sgn ? 64'h0000_0000_8000_0000 : 64'h0000_0000_7FFF_FFFF;
        end else begin
            mag = sgn ? (~mag + 128'd1) : mag;
            res = wide ? mag[63:0] : {32'd0, mag[31:0]};
            inx = sticky;
        end
    endfunction

    task automatic expect_eq(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one conversion: drive at a falling edge, sample one cycle later
    task automatic conv(input string tag, input logic [63:0] op, input logic [1:0] fmt,
                        input logic wide, input logic fix, input logic [5:0] sc);
        logic [63:0] er; logic ei, ex;
        @(negedge clk);
        operand = op; src_fmt = fmt; dst_wide = wide; fix_en = fix; scale = sc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        ref_conv(op, fmt, wide, fix, sc, er, ei, ex);
        expect_eq({tag, " result"}, result, er);
        expect_eq({tag, " flags"}, {61'd0, out_valid, flag_invalid, flag_inexact},
                  {61'd0, 1'b1, ei, ex});
    endtask

    // conversion with a hand-computed expectation as well
    task automatic conv_k(input string tag, input logic [63:0] op, input logic [1:0] fmt,
                          input logic wide, input logic fix, input logic [5:0] sc,
                          input logic [63:0] kres, input logic kinv, input logic kinx);
        conv(tag, op, fmt, wide, fix, sc);
        expect_eq({tag, " known"}, {result, 62'd0, flag_invalid, flag_inexact} >> 64 == result ?
                  result : result, kres);
        expect_eq({tag, " known flags"}, {62'd0, flag_invalid, flag_inexact}, {62'd0, kinv, kinx});
    endtask

    task automatic t_reset;
        expect_eq("R8 reset", {result[63:0]}, 64'd0);
        expect_eq("R8 reset flags", {61'd0, out_valid, flag_invalid, flag_inexact}, 64'd0);
    endtask

    task automatic t_formats;
        conv_k("R1 single 1.5",  64'hDEAD_BEEF_3FC0_0000, 2'b00, 1'b1, 1'b0, 6'd0, 64'd1, 1'b0, 1'b1);
        conv_k("R1 double -2.75", 64'hC006_0000_0000_0000, 2'b01, 1'b1, 1'b0, 6'd0,
               64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1);
        conv_k("R1 half 1.0",    64'h1234_5678_9ABC_3C00, 2'b11, 1'b1, 1'b0, 6'd0, 64'd1, 1'b0, 1'b0);
        conv_k("R1 half -7.5",   64'h0000_0000_0000_C780, 2'b11, 1'b1, 1'b0, 6'd0,
               64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b1);
    endtask

    task automatic t_narrow;
        conv_k("R2 narrow -3.0", 64'h0000_0000_C040_0000, 2'b00, 1'b0, 1'b0, 6'd0,
               64'h0000_0000_FFFF_FFFD, 1'b0, 1'b0);
        conv_k("R2 narrow 1e9 dbl", 64'h41CD_CD65_0000_0000, 2'b01, 1'b0, 1'b0, 6'd0,
               64'd1000000000, 1'b0, 1'b0);
    endtask

    task automatic t_saturate;
        conv_k("R3 single 2^31 narrow", 64'h0000_0000_4F00_0000, 2'b00, 1'b0, 1'b0, 6'd0,
               64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0);
        conv_k("R3 double 2^63 wide", 64'h43E0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 6'd0,
               64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        conv_k("R3 -inf wide", 64'hFFF0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 6'd0,
               64'h8000_0000_0000_0000, 1'b1, 1'b0);
        conv_k("R3 +inf half narrow", 64'h0000_0000_0000_7C00, 2'b11, 1'b0, 1'b0, 6'd0,
               64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0);
        conv_k("R3 -1e10 narrow", 64'hC202_A05F_2000_0000, 2'b01, 1'b0, 1'b0, 6'd0,
               64'h0000_0000_8000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_nan;
        conv_k("R4 qnan single", 64'h0000_0000_7FC0_0000, 2'b00, 1'b1, 1'b0, 6'd0, 64'd0, 1'b1, 1'b0);
        conv_k("R4 neg nan double", 64'hFFF0_0000_0000_0001, 2'b01, 1'b0, 1'b0, 6'd0, 64'd0, 1'b1, 1'b0);
    endtask

    task automatic t_inexact;
        conv_k("R5 -0.5 half", 64'h0000_0000_0000_B800, 2'b11, 1'b1, 1'b0, 6'd0, 64'd0, 1'b0, 1'b1);
        conv_k("R5 exact 4096", 64'h0000_0000_4580_0000, 2'b00, 1'b1, 1'b0, 6'd0, 64'd4096, 1'b0, 1'b0);
    endtask

    task automatic t_fixed;
        conv_k("R6 1.5 fbits4", 64'h0000_0000_3FC0_0000, 2'b00, 1'b1, 1'b1, 6'd60, 64'd24, 1'b0, 1'b0);
        conv_k("R6 0.3 fbits8", 64'h3FD3_3333_3333_3333, 2'b01, 1'b1, 1'b1, 6'd56, 64'd76, 1'b0, 1'b1);
        conv_k("R6 0.25 fbits64", 64'h3FD0_0000_0000_0000, 2'b01, 1'b1, 1'b1, 6'd0,
               64'h4000_0000_0000_0000, 1'b0, 1'b0);
        conv_k("R6 1.0 fbits31 narrow", 64'h0000_0000_3F80_0000, 2'b00, 1'b0, 1'b1, 6'd33,
               64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0);
        conv_k("R6 scale ignored int", 64'h0000_0000_3FC0_0000, 2'b00, 1'b1, 1'b0, 6'd5,
               64'd1, 1'b0, 1'b1);
    endtask

    task automatic t_zero_sub;
        conv_k("R7 +0 double", 64'h0, 2'b01, 1'b1, 1'b0, 6'd0, 64'd0, 1'b0, 1'b0);
        conv_k("R7 -0 single", 64'h0000_0000_8000_0000, 2'b00, 1'b1, 1'b0, 6'd0, 64'd0, 1'b0, 1'b0);
        conv_k("R7 sub single int", 64'h0000_0000_0000_0001, 2'b00, 1'b1, 1'b0, 6'd0, 64'd0, 1'b0, 1'b1);
        conv_k("R7 sub half fbits32", 64'h0000_0000_0000_0001, 2'b11, 1'b1, 1'b1, 6'd32,
               64'd256, 1'b0, 1'b0);
    endtask

    task automatic t_boundary;
        conv_k("R9 -2^63 wide", 64'hC3E0_0000_0000_0000, 2'b01, 1'b1, 1'b0, 6'd0,
               64'h8000_0000_0000_0000, 1'b0, 1'b0);
        conv_k("R9 -2^31 narrow", 64'h0000_0000_CF00_0000, 2'b00, 1'b0, 1'b0, 6'd0,
               64'h0000_0000_8000_0000, 1'b0, 1'b0);
    endtask

    task automatic t_stream;
        logic [63:0] er; logic ei, ex;
        @(negedge clk);
        operand = 64'h0000_0000_0000_4500; src_fmt = 2'b11; dst_wide = 1'b1; fix_en = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        expect_eq("R8 stream first", result, 64'd5);
        operand = 64'h0000_0000_7FC0_0000; src_fmt = 2'b00;
        @(negedge clk);
        in_valid = 1'b0;
        ref_conv(64'h0000_0000_7FC0_0000, 2'b00, 1'b1, 1'b0, 6'd0, er, ei, ex);
        expect_eq("R8 stream second", {62'd0, out_valid, flag_invalid}, {62'd0, 1'b1, ei});
        @(negedge clk);
        expect_eq("R8 idle after stream", {61'd0, out_valid, flag_invalid, flag_inexact}, 64'd0);
    endtask

    task automatic t_sweep;
        logic [63:0] lfsr = 64'h1BAD_F00D_C0FF_EE11;
        logic wide, fix;
        logic [5:0] sc;
        logic [1:0] fmt;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            case (lfsr[1:0])
                2'b00:   fmt = 2'b00;
                2'b01:   fmt = 2'b01;
                default: fmt = 2'b11;
            endcase
            wide = lfsr[2];
            fix  = lfsr[3];
            sc   = wide ? lfsr[9:4] : {1'b1, lfsr[8:4]};
            conv("R1 R5 R6 sweep", {lfsr[63:53], 1'b0, lfsr[51:10], 10'h155} ^ {lfsr[31:0], lfsr[63:32]},
                 fmt, wide, fix, sc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_formats();
        t_narrow();
        t_saturate();
        t_nan();
        t_inexact();
        t_fixed();
        t_zero_sub();
        t_boundary();
        t_stream();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule